// File: doc/BRIEF.md
# ATA Drive-Select Bus Responder

This block decides, access by access, whether a host-side adapter owns the ATA/IDE data bus. It watches the host's register-write bus for writes to the Drive/Head task-file register. Such a write may arrive at the primary base or at the secondary base. From each such write it keeps the drive-number bit (data bit 4). A small configuration register holds two fields. One turns master/slave arbitration on. The other gives the drive number this adapter answers to.

When arbitration is on, the bus-drive enable is high only while the kept drive bit equals the configured identity. When arbitration is off, the adapter always answers, so a single-drive system works with no setup. The reserved part of the configuration register returns a fixed variant code, which lets software tell product variants apart from the read-back value.

Top module: `ata_drive_responder`

## Requirements
- R1: After reset the configuration read-back equals the variant code with bits 1:0 cleared (default 10h), the kept drive bit is 0, and `busDriveEn` is 1.
- R2: A configuration write (`cfgWrEn` high at a rising edge) stores data bit 0 as the arbitration enable and data bit 1 as the drive identity; both appear on `cfgRdData[1:0]` from the next cycle on.
- R3: Configuration bits 7:2 ignore writes and always read the upper bits of the variant code.
- R4: With the arbitration enable at 0, `busDriveEn` is 1 whatever the kept drive bit is.
- R5: With the enable at 1 and identity 1, `busDriveEn` is 1 exactly when the last Drive/Head write carried a 1 in bit 4.
- R6: With the enable at 1 and identity 0, `busDriveEn` is 1 exactly when the last Drive/Head write carried a 0 in bit 4.
- R7: A write with `regWrEn` high to 10-bit address 1F6h (primary base 1F0h plus offset 6) updates the kept drive bit from data bit 4 only, and the effect shows on `busDriveEn` from the cycle after the edge.
- R8: A write to 10-bit address 176h (secondary base 170h plus offset 6) updates the kept drive bit in the same way.
- R9: Writes to any other address, including neighbouring task-file offsets and addresses that differ only in the upper bits, leave the kept drive bit unchanged.
- R10: With `regWrEn` low, a Drive/Head address and data on the bus change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| regAddr | input | 10 | Host I/O register address |
| regWrData | input | 8 | Host write data |
| regWrEn | input | 1 | Host register write strobe |
| cfgWrEn | input | 1 | Configuration register write strobe |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration register read-back |
| busDriveEn | output | 1 | High when the adapter should drive the ATA data bus |

## Verification
A wrong kept drive bit or identity shows on `busDriveEn` in the cycle right after the write that set it. It shows only while arbitration is on, so the bench runs both identities with arbitration on and flips the drive bit through both bases. A missed or false address match shows after one cycle as a missing or stray change on `busDriveEn`. A corrupted configuration field shows on `cfgRdData` one cycle after the write.

// File: rtl/ata_resp_pkg.sv
package ata_resp_pkg;
  typedef struct packed {
    logic loadCfg;
    logic latchDrive;
  } ctlStrobe_t;
endpackage

// File: rtl/ata_resp_ctrl.sv
module ata_resp_ctrl
  import ata_resp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] PRI_BASE = 10'h1F0,
  parameter logic [ADDR_W-1:0] SEC_BASE = 10'h170,
  parameter int DH_OFFSET = 6
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              cfgWrEn,
  output ctlStrobe_t        strobe
);
  localparam int NUM_BASES = 2;
  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(DH_OFFSET);
  localparam logic [ADDR_W-1:0] DH_ADDR [NUM_BASES] = '{PRI_BASE + OFFS, SEC_BASE + OFFS};

  logic [NUM_BASES-1:0] baseHit;

  // one comparator per task-file base
  for (genvar gi = 0; gi < NUM_BASES; gi++) begin : gHit
    assign baseHit[gi] = (regAddr == DH_ADDR[gi]);
  end

  always_comb begin
    strobe.latchDrive = regWrEn && (|baseHit);
    strobe.loadCfg    = cfgWrEn;
  end
endmodule

// File: rtl/ata_resp_dp.sv
module ata_resp_dp
  import ata_resp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DRIVE_BIT = 4,
  parameter logic [DATA_W-1:0] VARIANT_TAG = 'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] cfgRdData,
  output logic              busDriveEn
);
  localparam int RSVD_W = DATA_W - 2;
  localparam logic [RSVD_W-1:0] RSVD_VAL = VARIANT_TAG[DATA_W-1:2];

  logic msEnable;
  logic idBit;
  logic drvBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msEnable <= 1'b0;
      idBit    <= 1'b0;
      drvBit   <= 1'b0;
    end else begin
      if (strobe.loadCfg) begin
        msEnable <= cfgWrData[0];
        idBit    <= cfgWrData[1];
      end
      if (strobe.latchDrive) drvBit <= regWrData[DRIVE_BIT];
    end
  end

  assign cfgRdData  = {RSVD_VAL, idBit, msEnable};
  assign busDriveEn = !msEnable || (drvBit == idBit);
endmodule

// File: rtl/ata_drive_responder.sv
module ata_drive_responder
  import ata_resp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PRI_BASE = 10'h1F0,
  parameter logic [ADDR_W-1:0] SEC_BASE = 10'h170,
  parameter int DH_OFFSET = 6,
  parameter int DRIVE_BIT = 4,
  parameter logic [DATA_W-1:0] VARIANT_TAG = 'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] cfgRdData,
  output logic              busDriveEn
);
  ctlStrobe_t strobe;

  ata_resp_ctrl #(
    .ADDR_W(ADDR_W), .PRI_BASE(PRI_BASE), .SEC_BASE(SEC_BASE), .DH_OFFSET(DH_OFFSET)
  ) uCtrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .cfgWrEn(cfgWrEn), .strobe(strobe)
  );

  ata_resp_dp #(
    .DATA_W(DATA_W), .DRIVE_BIT(DRIVE_BIT), .VARIANT_TAG(VARIANT_TAG)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrData(regWrData),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .busDriveEn(busDriveEn)
  );
endmodule

// File: rtl/ata_drive_responder_chk.sv
module ata_drive_responder_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PRI_BASE = 10'h1F0,
  parameter logic [ADDR_W-1:0] SEC_BASE = 10'h170,
  parameter int DH_OFFSET = 6,
  parameter int DRIVE_BIT = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              regWrEn,
  input logic              cfgWrEn,
  input logic [DATA_W-1:0] cfgWrData,
  input logic [DATA_W-1:0] cfgRdData,
  input logic              busDriveEn
);
  localparam logic [ADDR_W-1:0] PRI_DH = PRI_BASE + ADDR_W'(DH_OFFSET);
  localparam logic [ADDR_W-1:0] SEC_DH = SEC_BASE + ADDR_W'(DH_OFFSET);

  logic priWr, secWr;
  assign priWr = regWrEn && (regAddr == PRI_DH);
  assign secWr = regWrEn && (regAddr == SEC_DH);

  AST_DISABLED_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdData[0] |-> busDriveEn); // R4
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData[1:0] == $past(cfgWrData[1:0])); // R2
  AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> $stable(cfgRdData[DATA_W-1:2])); // R3
  AST_PRI_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    priWr |=> busDriveEn == (!cfgRdData[0] || ($past(regWrData[DRIVE_BIT]) == cfgRdData[1]))); // R7
  AST_SEC_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    secWr |=> busDriveEn == (!cfgRdData[0] || ($past(regWrData[DRIVE_BIT]) == cfgRdData[1]))); // R8
  AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rstN)
    (!priWr && !secWr && !cfgWrEn) |=> $stable(busDriveEn)); // R9
endmodule

bind ata_drive_responder ata_drive_responder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRI_BASE(PRI_BASE), .SEC_BASE(SEC_BASE),
  .DH_OFFSET(DH_OFFSET), .DRIVE_BIT(DRIVE_BIT)
) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
  .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .busDriveEn(busDriveEn)
);

// File: tb/ata_drive_responder_test.sv
`timescale 1ns/1ps
module ata_drive_responder_test;
  localparam logic [7:0] TAG = 8'h10;

  typedef struct {
    string req;
    logic  expEn;
    logic [7:0] expCfg;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic regWrEn = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic busDriveEn;

  always #2 clk = ~clk;

  ata_drive_responder uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .busDriveEn(busDriveEn)
  );

  expItem_t scoreQ[$];
  int vecCount = 0;
  int missCount = 0;
  logic mEn = 1'b0, mId = 1'b0, mDrv = 1'b0;

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  endtask

  // driver: one operation per cycle, model predicts the post-edge outputs
  task automatic step(input logic [9:0] a, input logic [7:0] d, input logic we,
                      input logic cwe, input logic [7:0] cd, input string req);
    expItem_t it;
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = we; cfgWrEn = cwe; cfgWrData = cd;
    @(posedge clk);
    if (cwe) begin mEn = cd[0]; mId = cd[1]; end
    if (we && (a == 10'h1F6 || a == 10'h176)) mDrv = d[4];
    it.req = req;
    it.expEn = !mEn || (mDrv == mId);
    it.expCfg = {TAG[7:2], mId, mEn};
    scoreQ.push_back(it);
  endtask

  // monitor: compares between edges
  always @(negedge clk) begin
    if (scoreQ.size() > 0) begin
      expItem_t it;
      it = scoreQ.pop_front();
      vecCount++;
      if (busDriveEn !== it.expEn) begin
        missCount++;
        $display("FAIL %s busDriveEn actual=%b expected=%b", it.req, busDriveEn, it.expEn);
      end
      if (cfgRdData !== it.expCfg) begin
        missCount++;
        $display("FAIL %s cfgRdData actual=%h expected=%h", it.req, cfgRdData, it.expCfg);
      end
    end
  end

  initial begin
    #(200000 * 4);
    missCount++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    step(10'h000, 8'h00, 1'b0, 1'b0, 8'h00, "R1");
    step(10'h000, 8'h00, 1'b0, 1'b1, 8'hFD, "R2 R3");
    step(10'h1F6, 8'h10, 1'b1, 1'b0, 8'h00, "R7 R6");
    step(10'h176, 8'h00, 1'b1, 1'b0, 8'h00, "R8 R6");
    step(10'h000, 8'h00, 1'b0, 1'b1, 8'h03, "R2 R5");
    step(10'h176, 8'h10, 1'b1, 1'b0, 8'h00, "R8 R5");
    step(10'h1F7, 8'h00, 1'b1, 1'b0, 8'h00, "R9");
    step(10'h1F5, 8'h00, 1'b1, 1'b0, 8'h00, "R9");
    step(10'h3F6, 8'h00, 1'b1, 1'b0, 8'h00, "R9");
    step(10'h0F6, 8'h00, 1'b1, 1'b0, 8'h00, "R9");
    step(10'h1F6, 8'h00, 1'b0, 1'b0, 8'h00, "R10");
    step(10'h1F6, 8'hEF, 1'b1, 1'b0, 8'h00, "R7 R5");
    step(10'h000, 8'h00, 1'b0, 1'b1, 8'hFC, "R4 R3");
    step(10'h1F6, 8'h10, 1'b1, 1'b0, 8'h00, "R4");
    step(10'h000, 8'h00, 1'b0, 1'b1, 8'h01, "R2 R6");
    step(10'h000, 8'h00, 1'b0, 1'b0, 8'h00, "R10");
    @(negedge clk);
    regWrEn = 1'b0; cfgWrEn = 1'b0;
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule